// File: doc/BRIEF.md
# Sliding-Window Reuse Buffer

This block sits between an on-chip block RAM and a compute datapath whose loop slides a fixed-size window across an input array. Words arrive from memory one at a time through a valid/ready handshake and are written into a circular buffer of `DEPTH` slots. When every word of the next window is present, the whole window is presented to the datapath in parallel. Once the datapath takes it, the buffer advances by the loop stride. The words that consecutive windows share stay in place, so each array element is read from memory only once.

Each possible window start slot has its own fill detector, so there are `DEPTH` overlapping windows on the ring. Only the window whose start matches the current base pointer may be granted. Slots that the remaining windows no longer need are freed when a window is consumed. New memory data can refill those slots while a later window is still being presented. A frame ends with a word flagged as last. The buffer then exports every remaining complete window, discards any leftover partial window and returns to empty for the next frame.

A second copy of the same block can collect datapath results on the output side. Window size, stride, depth and word width are parameters, with `STRIDE <= WIN <= DEPTH`.

Top module: `win_reuse_buf`

## Requirements
- R1: After reset, `in_ready` is 1 and `win_valid` is 0.
- R2: In a frame whose accepted words are a[0], a[1], ..., the k-th exported window carries a[k*STRIDE + j] in element j, which is bits `[j*DATA_W +: DATA_W]` of `win_data`. Element 0 holds the lowest array index, wherever the words sit physically in the ring.
- R3: Windows are exported in order k = 0, 1, 2, ..., each exactly once. A frame of N >= WIN words yields exactly (N-WIN)/STRIDE+1 windows, using integer division.
- R4: `win_valid` is 1 only when all WIN words of the current window have been written. A frame shorter than WIN words exports no window.
- R5: While `win_valid` is 1 and `win_ready` is 0, `win_valid` stays 1 and `win_data` stays unchanged in the next cycle.
- R6: A slot is never overwritten while a window that has not yet been exported still needs it. When the buffer holds DEPTH such words, `in_ready` is 0, and every offered word is accepted exactly once.
- R7: When the current window cannot complete after the last word of a frame, the leftover words are discarded. In the next cycle `in_ready` is 1 and `win_valid` is 0, and the following frame starts again at array index 0.
- R8: From the cycle after the word flagged `in_last` is accepted until the frame has drained, `in_ready` is 0.
- R9: The same behaviour holds for a stride other than one, for example STRIDE=2, WIN=6, DEPTH=9.
- R10: At most one of the DEPTH per-window grants is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Memory word offered |
| in_data | input | DATA_W | Memory word |
| in_last | input | 1 | Offered word is the last of its frame |
| in_ready | output | 1 | Buffer can accept the offered word |
| win_valid | output | 1 | A complete window is presented |
| win_data | output | WIN*DATA_W | Window words, element 0 in the low bits |
| win_ready | input | 1 | Datapath takes the presented window |

## Verification
On every cycle the assertions check the following properties:
- At most one per-window grant is active.
- A presented window is held steady under backpressure.
- An occupancy count kept by the checker never exceeds the ring and is at least WIN whenever a window is presented.
- Accepting the last word closes the input.
- A drain leaves the buffer empty and open.

Only the bench's scenarios can show the rest:
- The window contents and their ordering.
- The exact number of windows per frame.
- Input stalling while a full ring waits on the datapath.
- Short-frame discard.
- The stride-two configuration.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  // (p + inc) reduced into [0, depth); requires p < depth and inc <= depth
  function automatic int unsigned wrap_add(input int unsigned p,
                                           input int unsigned inc,
                                           input int unsigned depth);
    int unsigned s;
    s = p + inc;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // forward distance from slot 'from' to slot 'to' on a ring of 'depth'
  function automatic int unsigned ring_dist(input int unsigned from,
                                            input int unsigned to,
                                            input int unsigned depth);
    if (to >= from) return to - from;
    return to + depth - from;
  endfunction

endpackage

// File: rtl/wrb_slot_track.sv
module wrb_slot_track #(
  parameter int DEPTH = 7,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DEPTH-1:0] clr_mask,
  input  logic             flush,
  output logic [DEPTH-1:0] slot_vld,
  output logic [PW-1:0]    wr_ptr
);
  import wrb_pkg::*;

  logic [DEPTH-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (wr_en) set_mask = DEPTH'(1) << wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      slot_vld <= '0;
      wr_ptr   <= '0;
    end else begin
      slot_vld <= (slot_vld & ~clr_mask) | set_mask;
      if (wr_en) wr_ptr <= PW'(wrap_add(32'(wr_ptr), 1, DEPTH));
    end
  end

endmodule

// File: rtl/wrb_window_ctl.sv
module wrb_window_ctl #(
  parameter int DEPTH  = 7,
  parameter int WIN    = 5,
  parameter int STRIDE = 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] slot_vld,
  input  logic             last_acc,
  input  logic             win_ready,
  output logic [PW-1:0]    base_ptr,
  output logic [DEPTH-1:0] win_full,
  output logic [DEPTH-1:0] win_grant,
  output logic             win_valid,
  output logic             last_seen,
  output logic [DEPTH-1:0] clr_mask,
  output logic             drain
);
  import wrb_pkg::*;

  logic adv;

  // one fill detector and one grant per possible window start slot
  for (genvar w = 0; w < DEPTH; w++) begin : g_win
    logic [WIN-1:0] member_vld;
    for (genvar j = 0; j < WIN; j++) begin : g_mem
      assign member_vld[j] = slot_vld[(w + j) % DEPTH];
    end
    assign win_full[w]  = &member_vld;
    assign win_grant[w] = win_full[w] && (base_ptr == PW'(w));
  end

  assign win_valid = |win_grant;
  assign adv       = win_valid && win_ready;
  // after the last word no write can complete the current window
  assign drain     = last_seen && !win_valid;

  // free the STRIDE oldest slots once their last window has been taken
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      clr_mask[s] = adv && (ring_dist(32'(base_ptr), s, DEPTH) < STRIDE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_ptr  <= '0;
      last_seen <= 1'b0;
    end else if (drain) begin
      base_ptr  <= '0;
      last_seen <= 1'b0;
    end else begin
      if (adv)      base_ptr  <= PW'(wrap_add(32'(base_ptr), STRIDE, DEPTH));
      if (last_acc) last_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/wrb_window_mux.sv
module wrb_window_mux #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 7,
  parameter int WIN    = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [PW-1:0]         wr_ptr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [PW-1:0]         base_ptr,
  output logic [WIN*DATA_W-1:0] win_data
);
  import wrb_pkg::*;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  // element j comes from the slot j places after the window start
  for (genvar j = 0; j < WIN; j++) begin : g_elem
    logic [PW-1:0] rd_idx;
    assign rd_idx = PW'(wrap_add(32'(base_ptr), j, DEPTH));
    assign win_data[j*DATA_W +: DATA_W] = store[rd_idx];
  end

endmodule

// File: rtl/win_reuse_buf.sv
module win_reuse_buf #(
  parameter int DATA_W = 16,
  parameter int WIN    = 5,
  parameter int STRIDE = 1,
  parameter int DEPTH  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  in_last,
  output logic                  in_ready,
  output logic                  win_valid,
  output logic [WIN*DATA_W-1:0] win_data,
  input  logic                  win_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slot_vld;
  logic [DEPTH-1:0] clr_mask;
  logic [DEPTH-1:0] win_full;
  logic [DEPTH-1:0] win_grant;
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    base_ptr;
  logic             last_seen;
  logic             frame_drain;
  logic             wr_fire;

  assign in_ready = !slot_vld[wr_ptr] && !last_seen;
  assign wr_fire  = in_valid && in_ready;

  wrb_slot_track #(.DEPTH(DEPTH)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .clr_mask (clr_mask),
    .flush    (frame_drain),
    .slot_vld (slot_vld),
    .wr_ptr   (wr_ptr)
  );

  wrb_window_ctl #(.DEPTH(DEPTH), .WIN(WIN), .STRIDE(STRIDE)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_vld  (slot_vld),
    .last_acc  (wr_fire && in_last),
    .win_ready (win_ready),
    .base_ptr  (base_ptr),
    .win_full  (win_full),
    .win_grant (win_grant),
    .win_valid (win_valid),
    .last_seen (last_seen),
    .clr_mask  (clr_mask),
    .drain     (frame_drain)
  );

  wrb_window_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WIN(WIN)) u_mux (
    .clk      (clk),
    .wr_en    (wr_fire),
    .wr_ptr   (wr_ptr),
    .wr_data  (in_data),
    .base_ptr (base_ptr),
    .win_data (win_data)
  );

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int DATA_W = 16,
  parameter int WIN    = 5,
  parameter int STRIDE = 1,
  parameter int DEPTH  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_last,
  input logic                  in_ready,
  input logic                  win_valid,
  input logic [WIN*DATA_W-1:0] win_data,
  input logic                  win_ready,
  input logic [DEPTH-1:0]      grant,
  input logic                  drain
);
  localparam int OW = $clog2(DEPTH + 1) + 2;

  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n || drain) occ <= '0;
    else occ <= occ + OW'(in_valid && in_ready)
                    - ((win_valid && win_ready) ? OW'(STRIDE) : OW'(0));
  end

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !win_ready |=> win_valid && $stable(win_data)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH)); // R6
  AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> occ >= OW'(WIN)); // R4
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready); // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain |=> in_ready && !win_valid); // R7

endmodule

bind win_reuse_buf wrb_checker #(
  .DATA_W(DATA_W), .WIN(WIN), .STRIDE(STRIDE), .DEPTH(DEPTH)
) u_wrb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .win_valid (win_valid),
  .win_data  (win_data),
  .win_ready (win_ready),
  .grant     (win_grant),
  .drain     (frame_drain)
);

// File: tb/win_reuse_buf_bench.sv
module win_reuse_buf_bench;
  localparam int W    = 16;
  localparam int MAXE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int sel = 0;
  logic [7:0] lfsr = 8'h5a;

  logic d_valid = 1'b0, d_last = 1'b0, d_wready = 1'b0;
  logic [W-1:0] d_data = '0;

  logic a_in_ready, a_win_valid, b_in_ready, b_win_valid;
  logic [5*W-1:0] a_win_data;
  logic [6*W-1:0] b_win_data;

  win_reuse_buf #(.DATA_W(W), .WIN(5), .STRIDE(1), .DEPTH(7)) u_win_reuse_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid && sel == 0), .in_data(d_data),
    .in_last(d_last), .in_ready(a_in_ready), .win_valid(a_win_valid),
    .win_data(a_win_data), .win_ready(d_wready));

  win_reuse_buf #(.DATA_W(W), .WIN(6), .STRIDE(2), .DEPTH(9)) u_win_reuse_buf_s2 (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid && sel == 1), .in_data(d_data),
    .in_last(d_last), .in_ready(b_in_ready), .win_valid(b_win_valid),
    .win_data(b_win_data), .win_ready(d_wready));

  logic o_in_ready, o_win_valid;
  logic [MAXE*W-1:0] o_win_data;
  assign o_in_ready  = (sel == 0) ? a_in_ready  : b_in_ready;
  assign o_win_valid = (sel == 0) ? a_win_valid : b_win_valid;
  assign o_win_data  = (sel == 0) ? {{W{1'b0}}, a_win_data} : b_win_data;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int win_of(input int s); return s == 0 ? 5 : 6; endfunction
  function automatic int stride_of(input int s); return s == 0 ? 1 : 2; endfunction
  function automatic int depth_of(input int s); return s == 0 ? 7 : 9; endfunction

  // memory side: word i of the frame is base+i, each fetched once
  task automatic produce(input int n, input int base, input int gap, output int taken);
    int cyc = 0;
    taken = 0;
    while (taken < n) begin
      @(negedge clk);
      cyc++;
      d_valid = (gap == 0) || (cyc % 3 != 0);
      d_data  = W'(base + taken);
      d_last  = (taken == n - 1);
      #1;
      if (d_valid && o_in_ready) taken++;
    end
    @(negedge clk);
    d_valid = 1'b0;
    d_last  = 1'b0;
    check(o_in_ready == 1'b0 || n < win_of(sel), "R8", "in_ready after last",
          o_in_ready, 0);
  endtask

  task automatic consume(input int n, input int base, input int stall, output int got);
    int wn = win_of(sel), st = stride_of(sel);
    int expn = (n >= wn) ? (n - wn) / st + 1 : 0;
    int cyc = 0;
    got = 0;
    while (got < expn && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (stall == 1) d_wready = lfsr[0];
      else if (stall == 2) d_wready = (cyc > 30);
      else d_wready = 1'b1;
      #1;
      if (stall == 2 && cyc == 25 && n >= depth_of(sel) + 1)
        check(o_in_ready == 1'b0, "R6", "in_ready with ring full", o_in_ready, 0);
      if (o_win_valid && d_wready) begin
        logic [MAXE*W-1:0] exp = '0;
        for (int j = 0; j < wn; j++) exp[j*W +: W] = W'(base + got * st + j);
        check(o_win_data == exp, sel == 0 ? "R2" : "R9", $sformatf("window %0d", got),
              longint'(o_win_data[63:0]), longint'(exp[63:0]));
        got++;
      end
    end
    d_wready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      if (o_win_valid) begin
        got++;
        check(1'b0, "R4", "extra or partial window", 1, 0);
      end
    end
    check(got == expn, "R3", "window count", got, expn);
    check(o_in_ready == 1'b1 && o_win_valid == 1'b0, "R7", "drained idle",
          {o_in_ready, o_win_valid}, 2'b10);
  endtask

  task automatic run_frame(input int s, input int n, input int gap, input int stall);
    int taken, got;
    int base = 16'h100 * (n + 3 * s);
    sel = s;
    fork
      produce(n, base, gap, taken);
      consume(n, base, stall, got);
    join
    check(taken == n, "R6", "words taken exactly once", taken, n);
  endtask

  task automatic t_reset();
    #1;
    check(a_in_ready == 1'b1, "R1", "in_ready after reset", a_in_ready, 1);
    check(a_win_valid == 1'b0, "R1", "win_valid after reset", a_win_valid, 0);
    check(b_win_valid == 1'b0, "R1", "win_valid s2 after reset", b_win_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame(0, 12, 0, 0);   // R2 R3 basic stream
    run_frame(0, 23, 1, 1);   // R2 R5 wrap with gaps and backpressure
    run_frame(0, 30, 0, 2);   // R6 ring full stall
    run_frame(0, 3, 0, 0);    // R4 R7 short frame discarded
    run_frame(0, 5, 0, 0);    // R3 exactly one window
    run_frame(1, 13, 0, 0);   // R9 stride two, leftover word dropped
    run_frame(1, 20, 1, 1);   // R9 with backpressure
    run_frame(1, 30, 0, 2);   // R9 R6 ring full stall
    run_frame(1, 6, 0, 0);    // R9 single window
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule